// File: doc/BRIEF.md
# Vector Mask to Element Expander

This unit turns a compact bit mask into a full 128-bit vector register value. Each mask bit stands for one vector element and fills it entirely with ones when set, or with zeros when clear. The element size can be 8, 16, 32, 64 or 128 bits. The mask comes either from a 64-bit general-purpose operand or from a 16-bit immediate that is scattered across the instruction word.

The block receives a 32-bit instruction word, the general-purpose operand and a strobe. It decodes the element size from the instruction and drives the expanded value from an output register one clock later, together with a one-cycle valid pulse. A selector code outside the supported set, under the matching opcode and extended code, raises an illegal flag instead. In that case the result register keeps its old value. Instruction words that match neither form are ignored.

Top module: `mask_expand_unit`

## Requirements
- R1: With the selector field insn[20:16] = 10000, byte elements are used. Result byte k (bits 8k+7:8k, for k = 0..15) is 0xFF when gpr bit k is set and 0x00 when it is clear. Bits 7:0 of the operand therefore fill the lower 64-bit half and bits 15:8 fill the upper half. Every byte of a valid result is either 0x00 or 0xFF.
- R2: Selector 10001 selects 16-bit elements. Halfword k (k = 0..7) is all ones exactly when gpr bit k is set.
- R3: Selector 10010 selects 32-bit elements. Word k (k = 0..3) is all ones exactly when gpr bit k is set.
- R4: Selector 10011 selects 64-bit elements. The lower doubleword follows gpr bit 0 and the upper doubleword follows gpr bit 1.
- R5: Selector 10100 selects one 128-bit element. All 128 result bits equal gpr bit 0.
- R6: Operand bits above the count consumed by the selected size (16, 8, 4, 2 or 1 bits) have no effect on the result.
- R7: The immediate form always uses byte elements. Its 16-bit mask is {insn[15:6], insn[20:16], insn[0]}, with the most significant part first. Mask bits 15:8 drive the upper doubleword and bits 7:0 drive the lower doubleword.
- R8: The register forms are recognised by insn[31:26] = 000100 and insn[10:0] = 11001000010. The immediate form is recognised by insn[31:26] = 000100 and insn[5:1] = 01010. Any other word is ignored: it produces no valid, no illegal flag and no change to the result.
- R9: A register-form word whose selector is not one of 10000 to 10100 raises out_illegal for one cycle. out_valid stays low and the result register keeps its previous value.
- R10: The result and out_valid appear on the clock edge after the cycle in which in_valid is high. out_valid is high for exactly one cycle per accepted strobe.
- R11: A synchronous active-high reset clears the result to zero and deasserts out_valid and out_illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe: insn and gpr_src are valid this cycle |
| insn | input | 32 | Instruction word |
| gpr_src | input | 64 | General-purpose register operand supplying the mask |
| out_valid | output | 1 | One-cycle pulse: out_result holds a new value |
| out_illegal | output | 1 | One-cycle pulse: unsupported selector seen |
| out_result | output | 128 | Registered expanded vector value |

## Verification
A wrong size decode or a wrong bit-to-element mapping shows on out_result on the cycle after the strobe. It appears as a byte, halfword or word pattern that does not match the operand bits. A corrupted immediate field splice moves set bytes to the wrong positions. A fault in the strobe or legality logic shows as a missing, doubled or misplaced out_valid or out_illegal pulse within one cycle. A result register that updates on an illegal word shows as a changed out_result while out_illegal is high.

// File: rtl/mvm_pkg.sv
package mvm_pkg;

    localparam int VEC_W   = 128;
    localparam int HALF_W  = VEC_W / 2;
    localparam int GPR_W   = 64;
    localparam int INSN_W  = 32;
    localparam int MASK_W  = 16;
    localparam int N_SIZES = 4;   // element sizes 8..64 built per half

    localparam logic [5:0]  PRIMARY_OP = 6'b000100;
    localparam logic [10:0] REG_XO     = 11'b11001000010;
    localparam logic [4:0]  IMM_XO     = 5'b01010;

    typedef enum logic [2:0] {
        ESZ_BYTE  = 3'd0,
        ESZ_HALF  = 3'd1,
        ESZ_WORD  = 3'd2,
        ESZ_DWORD = 3'd3,
        ESZ_QUAD  = 3'd4
    } esz_e;

    typedef struct packed {
        logic              legal;
        logic              illegal;
        esz_e              esz;
        logic [MASK_W-1:0] mask;
    } decode_t;

    // Maps a selector code to an element size; flags unsupported codes.
    function automatic logic sel_to_esz(input logic [4:0] sel, output esz_e esz);
        esz = ESZ_BYTE;
        unique case (sel)
            5'b10000: begin esz = ESZ_BYTE;  return 1'b1; end
            5'b10001: begin esz = ESZ_HALF;  return 1'b1; end
            5'b10010: begin esz = ESZ_WORD;  return 1'b1; end
            5'b10011: begin esz = ESZ_DWORD; return 1'b1; end
            5'b10100: begin esz = ESZ_QUAD;  return 1'b1; end
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mvm_decoder.sv
module mvm_decoder
    import mvm_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    input  logic [GPR_W-1:0]  gpr_src,
    output decode_t           dec
);

    logic              primary_hit;
    logic              reg_hit;
    logic              imm_hit;
    logic              sel_ok;
    esz_e              sel_esz;
    logic [MASK_W-1:0] imm_mask;
    logic              unused_bits;

    assign primary_hit = (insn[31:26] == PRIMARY_OP);
    assign reg_hit     = primary_hit && (insn[10:0] == REG_XO);
    assign imm_hit     = primary_hit && (insn[5:1] == IMM_XO);

    // Immediate spliced from three fields, high part first.
    assign imm_mask    = {insn[15:6], insn[20:16], insn[0]};

    assign unused_bits = ^{insn[25:21], gpr_src[GPR_W-1:MASK_W]};

    always_comb begin
        sel_ok = sel_to_esz(insn[20:16], sel_esz);
        dec    = '0;
        if (reg_hit) begin
            dec.legal   = sel_ok;
            dec.illegal = !sel_ok;
            dec.esz     = sel_esz;
            dec.mask    = gpr_src[MASK_W-1:0];
        end else if (imm_hit) begin
            dec.legal   = 1'b1;
            dec.esz     = ESZ_BYTE;
            dec.mask    = imm_mask;
        end
    end

endmodule

// File: rtl/mvm_expander.sv
module mvm_expander
    import mvm_pkg::*;
#(
    parameter int VW = VEC_W,
    parameter int MW = MASK_W
) (
    input  esz_e          esz,
    input  logic [MW-1:0] mask,
    output logic [VW-1:0] vec
);

    localparam int HW = VW / 2;

    logic [VW-1:0] cand [N_SIZES];

    for (genvar w = 0; w < N_SIZES; w++) begin : g_size
        localparam int EW = 8 << w;
        localparam int EC = HW / EW;
        for (genvar k = 0; k < EC; k++) begin : g_elem
            assign cand[w][k*EW +: EW]      = {EW{mask[k]}};
            assign cand[w][HW + k*EW +: EW] = {EW{mask[EC + k]}};
        end
    end

    always_comb begin
        unique case (esz)
            ESZ_BYTE:  vec = cand[0];
            ESZ_HALF:  vec = cand[1];
            ESZ_WORD:  vec = cand[2];
            ESZ_DWORD: vec = cand[3];
            ESZ_QUAD:  vec = {VW{mask[0]}};
            default:   vec = '0;
        endcase
    end

endmodule

// File: rtl/mask_expand_unit.sv
module mask_expand_unit
    import mvm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic [GPR_W-1:0]  gpr_src,
    output logic              out_valid,
    output logic              out_illegal,
    output logic [VEC_W-1:0]  out_result
);

    decode_t          dec;
    logic [VEC_W-1:0] expanded;

    mvm_decoder u_dec (
        .insn    (insn),
        .gpr_src (gpr_src),
        .dec     (dec)
    );

    mvm_expander #(.VW(VEC_W), .MW(MASK_W)) u_exp (
        .esz  (dec.esz),
        .mask (dec.mask),
        .vec  (expanded)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            out_illegal <= 1'b0;
            out_result  <= '0;
        end else begin
            out_valid   <= in_valid && dec.legal;
            out_illegal <= in_valid && dec.illegal;
            if (in_valid && dec.legal) begin
                out_result <= expanded;
            end
        end
    end

endmodule

// File: rtl/mvm_checker.sv
module mvm_checker
    import mvm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic              out_illegal,
    input logic [VEC_W-1:0]  out_result
);

    logic bytes_uniform;

    always_comb begin
        bytes_uniform = 1'b1;
        for (int b = 0; b < VEC_W / 8; b++) begin
            if (out_result[b*8 +: 8] != 8'h00 && out_result[b*8 +: 8] != 8'hFF)
                bytes_uniform = 1'b0;
        end
    end

    // R1
    bytes_uniform_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> bytes_uniform);

    // R10
    valid_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));

    // R10
    quiet_without_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !out_illegal));

    // R9
    illegal_excl_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && out_illegal));

    // R9
    illegal_holds_result_chk: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> $stable(out_result));

    // R11
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && !out_illegal && out_result == '0));

endmodule

bind mask_expand_unit mvm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .out_valid   (out_valid),
    .out_illegal (out_illegal),
    .out_result  (out_result)
);

// File: tb/mask_expand_unit_bench.sv
module mask_expand_unit_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [31:0]  insn = '0;
    logic [63:0]  gpr_src = '0;
    logic         out_valid;
    logic         out_illegal;
    logic [127:0] out_result;

    int checks = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    mask_expand_unit u_mask_expand_unit (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .insn        (insn),
        .gpr_src     (gpr_src),
        .out_valid   (out_valid),
        .out_illegal (out_illegal),
        .out_result  (out_result)
    );

    function automatic logic [31:0] reg_word(input logic [4:0] sel);
        return {6'b000100, 5'd3, sel, 5'd7, 11'b11001000010};
    endfunction

    function automatic logic [31:0] imm_word(input logic [15:0] imm);
        return {6'b000100, 5'd2, imm[5:1], imm[15:6], 5'b01010, imm[0]};
    endfunction

    // Expected value: bit i follows mask bit i/ew; a 128-bit element uses bit 0.
    function automatic logic [127:0] model(input int ew, input logic [63:0] m);
        logic [127:0] r;
        for (int i = 0; i < 128; i++) r[i] = m[i / ew];
        return r;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issues one strobe and checks the cycle after, plus the cycle after that.
    task automatic issue(input string req, input logic [31:0] w, input logic [63:0] g,
                         input logic exp_v, input logic exp_i, input logic [127:0] exp_r);
        @(negedge clk);
        in_valid = 1'b1; insn = w; gpr_src = g;
        @(negedge clk);
        in_valid = 1'b0; insn = '0; gpr_src = '0;
        check({req, " valid"},   {127'b0, out_valid},   {127'b0, exp_v});
        check({req, " illegal"}, {127'b0, out_illegal}, {127'b0, exp_i});
        check({req, " result"},  out_result, exp_r);
        @(negedge clk);
        check({req, " R10 valid one cycle"}, {126'b0, out_valid, out_illegal}, 128'd0);
    endtask

    task automatic t_reset();
        check("R11 result", out_result, '0);
        check("R11 flags", {126'b0, out_valid, out_illegal}, 128'd0);
    endtask

    task automatic t_bytes();
        issue("R1 byte a5c3", reg_word(5'b10000), 64'h0000_0000_0000_A5C3, 1, 0, model(8, 64'hA5C3));
        issue("R1 byte 8001", reg_word(5'b10000), 64'h8001, 1, 0, model(8, 64'h8001));
        issue("R6 byte high bits ignored", reg_word(5'b10000), 64'hFFFF_FFFF_FFFF_0000, 1, 0, '0);
    endtask

    task automatic t_wider();
        issue("R2 half", reg_word(5'b10001), 64'hFF5A, 1, 0, model(16, 64'h5A));
        issue("R3 word", reg_word(5'b10010), 64'hFFF6, 1, 0, model(32, 64'h6));
        issue("R4 dword hi only", reg_word(5'b10011), 64'hFFFF_FFFC_0000_0002, 1, 0,
              {{64{1'b1}}, 64'h0});
        issue("R4 dword lo only", reg_word(5'b10011), 64'h1, 1, 0, {64'h0, {64{1'b1}}});
    endtask

    task automatic t_quad();
        issue("R5 quad set", reg_word(5'b10100), 64'h1, 1, 0, {128{1'b1}});
        issue("R5 R6 quad clear with high bits", reg_word(5'b10100), 64'hFFFF_FFFF_FFFF_FFFE,
              1, 0, '0);
    endtask

    task automatic t_imm();
        issue("R7 imm 8421", imm_word(16'h8421), 64'hFFFF, 1, 0, model(8, 64'h8421));
        issue("R7 imm 7ffe", imm_word(16'h7FFE), 64'h0, 1, 0, model(8, 64'h7FFE));
    endtask

    task automatic t_illegal();
        logic [127:0] held;
        issue("R9 setup", reg_word(5'b10000), 64'h00F0, 1, 0, model(8, 64'hF0));
        held = model(8, 64'hF0);
        issue("R9 sel 10101", reg_word(5'b10101), 64'hFFFF, 0, 1, held);
        issue("R9 sel 11111", reg_word(5'b11111), 64'h1, 0, 1, held);
        issue("R8 other opcode ignored", {6'b011111, reg_word(5'b10000)[25:0]}, 64'hFFFF,
              0, 0, held);
        issue("R8 other xo ignored", {reg_word(5'b10000)[31:11], 11'b11001000000}, 64'hFFFF,
              0, 0, held);
    endtask

    task automatic t_idle();
        @(negedge clk);
        insn = reg_word(5'b10000); gpr_src = 64'hFFFF;
        @(negedge clk);
        check("R10 no strobe no output", {126'b0, out_valid, out_illegal}, 128'd0);
        insn = '0; gpr_src = '0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_bytes();
        t_wider();
        t_quad();
        t_imm();
        t_illegal();
        t_idle();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog R10 actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule